// File: doc/BRIEF.md
# USB Host Root-Port Status and Control Register

This block holds the 32-bit status and control word of a single root-hub port on a USB 2.0 host. Software sees one register through a plain write strobe with full-word data and a combinational readback. Hardware events arrive from an abstracted port PHY: a connect level, an over-current level, a J-to-K resume strobe and a high-speed detection level. The block turns them into sticky change flags, port enable and suspend state, and the control levels that drive bus reset, resume signalling and suspend on the line.

Change flags are cleared by writing 1. The enable bit can only be set by hardware, at the end of a bus reset that found a high-speed device. A bus reset lasts a parameterised minimum number of clock cycles, and so does the return to high-speed idle after resume. The port-owner bit follows a global configured flag, so the port can be handed to a companion controller.

Top module: `hport_stsctl`

## Requirements
- R1: Bit 0 reads the connect level one cycle late. Bit 1 is set on every change of that level, even when it is already set, and is cleared by writing 1. A hardware set in the same cycle as a software clear leaves the bit at 1.
- R2: Writing 1 to bit 2 (port enabled) never sets it. Writing 0 clears it. Hardware sets it only at the end of a bus reset, and only when `hs_detect` is high at that moment.
- R3: A disconnect while bit 2 is set clears bit 2 and sets bit 3. A software disable leaves bit 3 at 0. Bit 3 is cleared by writing 1.
- R4: Bit 4 reads the over-current level one cycle late. Bit 5 is set on each change of that level and is cleared by writing 1.
- R5: A `jk_seen` strobe while bit 7 = 1 and bit 6 = 0 sets bit 6 and raises `chg_pulse` for exactly one cycle. A software write of 1 to bit 6 sets bit 6 without raising `chg_pulse`. `resume_drive_o` is high while bit 6 = 1 and no exit is pending.
- R6: Writing 0 to bit 6 while it is 1 starts an exit. Bit 6 stays 1 for RES_CYC further cycles, then clears, and bit 7 clears in the same cycle.
- R7: Writing 1 to bit 7 (suspend) sets it only when bit 2 = 1. Writing 0 is ignored. Starting a bus reset clears bit 7.
- R8: A write of 1 to bit 8 while it is 0 starts a bus reset and clears bit 2; `bus_reset_o` follows bit 8. A later write of 0 requests the end of the reset. Bit 8 falls only after at least RST_CYC cycles and never while `hc_halted` is high.
- R9: Bit 13 (owner) resets to 1. It is held at 1 while `cfg_flag` is 0 and goes to 0 on a rising edge of `cfg_flag`. Otherwise writes set its value.
- R10: Bits 19:16 (test mode), bit 20 (wake on connect) and bit 21 (wake on disconnect) are read/write and reset to 0.
- R11: While `pwr_on` is 0, bits 1, 2, 3, 6, 7, 8, 20 and 21 read 0 and ignore writes.
- R12: Bits 9–12, 14, 15 and 22–31 read 0. Writing 0 to bits 1, 3 or 5 leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register readback |
| pwr_on | input | 1 | Port power present |
| line_conn | input | 1 | Device connect level from PHY |
| oc_active | input | 1 | Over-current level from PHY |
| jk_seen | input | 1 | J-to-K transition strobe from PHY |
| hs_detect | input | 1 | High-speed device detected during reset |
| cfg_flag | input | 1 | Global configured flag |
| hc_halted | input | 1 | Controller halted; holds bus reset |
| chg_pulse | output | 1 | One-cycle port-change-detect pulse |
| bus_reset_o | output | 1 | Drive bus reset |
| resume_drive_o | output | 1 | Drive resume signalling |
| suspend_o | output | 1 | Port suspended |

## Verification
A hardware set of a change flag can land in the same clock edge as the software write that clears it. The bench provokes this by toggling `line_conn` in the same cycle as a write of 1 to bit 1, and expects bit 1 to read 1 afterwards. A second overlap is a reset-start write on a suspended port: suspend set and reset start fall in the same cycle, and the bench expects bit 7 to read 0 and bit 8 to read 1.

// File: rtl/hport_pkg.sv
package hport_pkg;
  localparam int B_CCS = 0;
  localparam int B_CSC = 1;
  localparam int B_PE  = 2;
  localparam int B_PEC = 3;
  localparam int B_OCA = 4;
  localparam int B_OCC = 5;
  localparam int B_FPR = 6;
  localparam int B_SUS = 7;
  localparam int B_PR  = 8;
  localparam int B_OWN = 13;
  localparam int B_TST = 16;
  localparam int TST_W = 4;
  localparam int B_WKC = 20;
  localparam int B_WKD = 21;

  // sticky flag: forced zero first, then set beats a write-one clear
  function automatic logic w1c_next(input logic cur, input logic set,
                                    input logic clr, input logic zero);
    if (zero) return 1'b0;
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/hport_tmr.sv
module hport_tmr #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt;

  assign done_o = (cnt == CW'(LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr_i)            cnt <= '0;
    else if (run_i && !done_o) cnt <= cnt + 1'b1;
  end

  p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LEN));
endmodule

// File: rtl/hport_flags.sv
module hport_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] zero_i,
  output logic [N-1:0] q_o
);
  import hport_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o[i] <= 1'b0;
      else        q_o[i] <= w1c_next(q_o[i], set_i[i], clr_i[i], zero_i[i]);
    end

    p_set_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[i] && !zero_i[i]) |=> q_o[i]);
    p_w0_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i[i] && !clr_i[i] && !zero_i[i]) |=> (q_o[i] == $past(q_o[i])));
  end
endmodule

// File: rtl/hport_stsctl.sv
module hport_stsctl #(
  parameter int RST_CYC = 16,
  parameter int RES_CYC = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        pwr_on,
  input  logic        line_conn,
  input  logic        oc_active,
  input  logic        jk_seen,
  input  logic        hs_detect,
  input  logic        cfg_flag,
  input  logic        hc_halted,
  output logic        chg_pulse,
  output logic        bus_reset_o,
  output logic        resume_drive_o,
  output logic        suspend_o
);
  import hport_pkg::*;

  localparam logic [31:0] OFF_MASK = (32'd1 << B_CSC) | (32'd1 << B_PE) |
    (32'd1 << B_PEC) | (32'd1 << B_FPR) | (32'd1 << B_SUS) | (32'd1 << B_PR) |
    (32'd1 << B_WKC) | (32'd1 << B_WKD);

  logic conn_q, oc_q, cfg_q, pe_q, pr_q, rel_q, fpr_q, ex_q, sus_q, own_q;
  logic wkc_q, wkd_q;
  logic [TST_W-1:0] tst_q;
  logic [2:0] flg_q;

  // named internal events
  logic conn_now, conn_chg, disc_fault, oc_chg, pr_start, rel_now, pr_end;
  logic rst_done, jk_acc, sw_fpr_set, fpr_exit_req, fpr_end, res_done;
  logic sw_pe_clr, sus_set, cfg_rise;

  assign conn_now     = pwr_on & line_conn;
  assign conn_chg     = conn_now ^ conn_q;
  assign disc_fault   = conn_q & ~conn_now & pe_q & pwr_on;
  assign oc_chg       = oc_active ^ oc_q;
  assign pr_start     = pwr_on & wr_en & wr_data[B_PR] & ~pr_q;
  assign rel_now      = rel_q | (wr_en & ~wr_data[B_PR]);
  assign pr_end       = pr_q & rel_now & rst_done & ~hc_halted;
  assign jk_acc       = pwr_on & jk_seen & sus_q & ~fpr_q;
  assign sw_fpr_set   = pwr_on & wr_en & wr_data[B_FPR] & ~fpr_q;
  assign fpr_exit_req = wr_en & ~wr_data[B_FPR] & fpr_q & ~ex_q;
  assign fpr_end      = ex_q & res_done;
  assign sw_pe_clr    = wr_en & ~wr_data[B_PE];
  assign sus_set      = pwr_on & wr_en & wr_data[B_SUS] & pe_q;
  assign cfg_rise     = cfg_flag & ~cfg_q;

  logic unused_bits;
  assign unused_bits = ^{wr_data[31:22], wr_data[15:14], wr_data[12:9],
                         wr_data[B_OCA], wr_data[B_CCS]};

  hport_tmr #(.LEN(RST_CYC)) u_rst_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(pr_start | ~pwr_on), .run_i(pr_q),
    .done_o(rst_done));

  hport_tmr #(.LEN(RES_CYC)) u_res_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(fpr_exit_req | ~pwr_on), .run_i(ex_q),
    .done_o(res_done));

  // flag order: 0 connect change, 1 enable change, 2 over-current change
  hport_flags #(.N(3)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_i({oc_chg, disc_fault, conn_chg}),
    .clr_i(wr_en ? {wr_data[B_OCC], wr_data[B_PEC], wr_data[B_CSC]} : 3'b000),
    .zero_i({1'b0, ~pwr_on, ~pwr_on}),
    .q_o(flg_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_q <= 1'b0; oc_q <= 1'b0; cfg_q <= 1'b0; chg_pulse <= 1'b0;
      pe_q <= 1'b0; pr_q <= 1'b0; rel_q <= 1'b0; fpr_q <= 1'b0;
      ex_q <= 1'b0; sus_q <= 1'b0; own_q <= 1'b1;
      tst_q <= '0; wkc_q <= 1'b0; wkd_q <= 1'b0;
    end else begin
      conn_q    <= conn_now;
      oc_q      <= oc_active;
      cfg_q     <= cfg_flag;
      chg_pulse <= jk_acc;
      // port enable: disconnect, reset start and power loss win
      if (sw_pe_clr) pe_q <= 1'b0;
      if (pr_end)    pe_q <= hs_detect;
      if (pr_start | disc_fault | ~pwr_on) pe_q <= 1'b0;
      // bus reset
      if (pr_start) begin
        pr_q <= 1'b1; rel_q <= 1'b0;
      end else if (pr_end) begin
        pr_q <= 1'b0; rel_q <= 1'b0;
      end else if (pr_q & wr_en & ~wr_data[B_PR]) begin
        rel_q <= 1'b1;
      end
      // resume
      if (jk_acc | sw_fpr_set) fpr_q <= 1'b1;
      if (fpr_exit_req) ex_q <= 1'b1;
      if (fpr_end) begin
        fpr_q <= 1'b0; ex_q <= 1'b0;
      end
      // suspend
      if (sus_set) sus_q <= 1'b1;
      if (fpr_end | pr_start | ~pwr_on) sus_q <= 1'b0;
      // owner
      if (wr_en)    own_q <= wr_data[B_OWN];
      if (cfg_rise) own_q <= 1'b0;
      if (!cfg_flag) own_q <= 1'b1;
      // test mode and wake enables
      if (wr_en) begin
        tst_q <= wr_data[B_TST +: TST_W];
        wkc_q <= wr_data[B_WKC];
        wkd_q <= wr_data[B_WKD];
      end
      if (!pwr_on) begin
        pr_q <= 1'b0; rel_q <= 1'b0; fpr_q <= 1'b0; ex_q <= 1'b0;
        wkc_q <= 1'b0; wkd_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[B_CCS] = conn_q;
    rd_data[B_CSC] = flg_q[0];
    rd_data[B_PE]  = pe_q;
    rd_data[B_PEC] = flg_q[1];
    rd_data[B_OCA] = oc_q;
    rd_data[B_OCC] = flg_q[2];
    rd_data[B_FPR] = fpr_q;
    rd_data[B_SUS] = sus_q;
    rd_data[B_PR]  = pr_q;
    rd_data[B_OWN] = own_q;
    rd_data[B_TST +: TST_W] = tst_q;
    rd_data[B_WKC] = wkc_q;
    rd_data[B_WKD] = wkd_q;
  end

  assign bus_reset_o    = pr_q;
  assign resume_drive_o = fpr_q & ~ex_q;
  assign suspend_o      = sus_q;

  p_pe_from_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pe_q) |-> $fell(pr_q));
  p_pulse_hw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chg_pulse |-> (fpr_q && $past(sus_q)));
  p_sus_with_fpr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fpr_q) |-> !sus_q);
  p_reset_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pr_q) && $past(pwr_on)) |-> ($past(rst_done) && !$past(hc_halted)));
  p_owner_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_flag |=> rd_data[B_OWN]);
  p_off_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> ((rd_data & OFF_MASK) == 32'd0));
endmodule

// File: tb/sim_hport_stsctl.sv
module sim_hport_stsctl;
  localparam int RST = 8;
  localparam int RES = 5;

  typedef struct packed {
    logic [31:0] wd;
    logic [31:0] ex;
  } vec_t;

  localparam vec_t VT [5] = '{
    '{wd: 32'h0000_002E, ex: 32'h0000_0000},
    '{wd: 32'h0025_0000, ex: 32'h0025_0000},
    '{wd: 32'h003A_2000, ex: 32'h003A_2000},
    '{wd: 32'hFFC0_DE00, ex: 32'h0000_0000},
    '{wd: 32'h0000_0080, ex: 32'h0000_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic pwr_on = 1'b1, line_conn = 1'b0, oc_active = 1'b0, jk_seen = 1'b0;
  logic hs_detect = 1'b0, cfg_flag = 1'b0, hc_halted = 1'b0;
  logic [31:0] rd_data;
  logic chg_pulse, bus_reset_o, resume_drive_o, suspend_o;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  hport_stsctl #(.RST_CYC(RST), .RES_CYC(RES)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwr_on(pwr_on), .line_conn(line_conn),
    .oc_active(oc_active), .jk_seen(jk_seen), .hs_detect(hs_detect),
    .cfg_flag(cfg_flag), .hc_halted(hc_halted), .chg_pulse(chg_pulse),
    .bus_reset_o(bus_reset_o), .resume_drive_o(resume_drive_o),
    .suspend_o(suspend_o));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  // full reset sequence, connect assumed present
  task automatic run_reset(input logic hs);
    hs_detect = hs;
    wr(32'h100);
    chk("R8 reset starts", {31'd0, bus_reset_o}, 32'd1);
    wr(32'h0);
    repeat (RST - 1) step();
    chk("R8 reset held", {31'd0, rd_data[8]}, 32'd1);
    step();
    chk("R8 R2 reset end", rd_data, {29'd0, hs, 2'b01});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R9 R10 reset state", rd_data, 32'h0000_2000);
    chk("R5 R8 reset outputs", {28'd0, chg_pulse, bus_reset_o, resume_drive_o, suspend_o}, 32'd0);
    cfg_flag = 1'b1; step();
    chk("R9 cfg rise", rd_data, 32'h0);

    for (int i = 0; i < 5; i++) begin
      wr(VT[i].wd);
      chk("R10 R12 R2 R7 table", rd_data, VT[i].ex);
    end

    // connect change, and set beating clear in one cycle
    line_conn = 1'b1; step();
    chk("R1 connect", rd_data, 32'h3);
    wr_en = 1'b1; wr_data = 32'h2; line_conn = 1'b0; step();
    wr_en = 1'b0; wr_data = '0;
    chk("R1 set wins", rd_data, 32'h2);
    wr(32'h2);
    chk("R1 w1c", rd_data, 32'h0);
    line_conn = 1'b1; step();
    wr(32'h0);
    chk("R12 write zero keeps", rd_data, 32'h3);
    wr(32'h2);
    chk("R1 clear", rd_data, 32'h1);

    run_reset(1'b1);
    // halted controller holds reset
    hs_detect = 1'b0; hc_halted = 1'b1;
    wr(32'h100); wr(32'h0);
    repeat (RST + 3) step();
    chk("R8 halted hold", rd_data, 32'h101);
    hc_halted = 1'b0; step();
    chk("R8 R2 low-speed end", rd_data, 32'h1);

    run_reset(1'b1);
    wr(32'h84);
    chk("R7 suspend set", rd_data, 32'h85);
    chk("R7 suspend out", {31'd0, suspend_o}, 32'd1);
    wr(32'h04);
    chk("R7 write zero ignored", rd_data, 32'h85);
    jk_seen = 1'b1; step(); jk_seen = 1'b0;
    chk("R5 hw resume", rd_data, 32'hC5);
    chk("R5 pulse and drive", {30'd0, chg_pulse, resume_drive_o}, 32'h3);
    step();
    chk("R5 one pulse", {31'd0, chg_pulse}, 32'd0);
    wr(32'h84);
    chk("R6 exit pending", {30'd0, rd_data[6], resume_drive_o}, 32'h2);
    repeat (RES) step();
    chk("R6 still resuming", {31'd0, rd_data[6]}, 32'd1);
    step();
    chk("R6 resume done", rd_data, 32'h05);
    wr(32'h44);
    chk("R5 sw resume", rd_data, 32'h45);
    chk("R5 no pulse", {31'd0, chg_pulse}, 32'd0);
    wr(32'h04);
    repeat (RES + 1) step();
    chk("R6 sw resume done", rd_data, 32'h05);

    // suspend and reset start in one write path
    wr(32'h84);
    wr(32'h100);
    chk("R7 R8 reset clears suspend", rd_data, 32'h101);
    hs_detect = 1'b1;
    wr(32'h0);
    repeat (RST) step();
    chk("R8 reset end", rd_data, 32'h5);

    line_conn = 1'b0; step();
    chk("R3 disconnect fault", rd_data, 32'hA);
    wr(32'h8);
    chk("R3 w1c", rd_data, 32'h2);
    wr(32'h2);
    line_conn = 1'b1; step();
    wr(32'h2);
    run_reset(1'b1);
    wr(32'h0);
    chk("R3 R2 sw disable", rd_data, 32'h1);

    oc_active = 1'b1; step();
    chk("R4 oc on", rd_data, 32'h31);
    oc_active = 1'b0; step();
    chk("R4 oc off", rd_data, 32'h21);
    wr(32'h20);
    chk("R4 w1c", rd_data, 32'h1);

    run_reset(1'b1);
    wr(32'h0035_0084);
    chk("R10 fields", rd_data, 32'h0035_0085);
    pwr_on = 1'b0; step();
    chk("R11 power off", rd_data, 32'h0005_0000);
    wr(32'h0030_0000);
    chk("R11 writes ignored", rd_data, 32'h0);
    pwr_on = 1'b1; step();
    chk("R1 power back", rd_data, 32'h3);
    wr(32'h2);

    cfg_flag = 1'b0; step();
    chk("R9 cfg low", rd_data, 32'h2001);
    wr(32'h0);
    chk("R9 held", rd_data, 32'h2001);
    cfg_flag = 1'b1; step();
    chk("R9 rise clears", rd_data, 32'h1);
    wr(32'h2000);
    chk("R9 release", rd_data, 32'h2001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule